// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, looking only at its 48-bit destination address. The address is first tried against a small table of perfect-match entries, each guarded by its own valid flag. When no entry matches, a 12-bit hash of the upper two address bytes indexes a 4096-bit multicast table. A set bit there accepts the frame.

Software loads both tables through a single-cycle write port. The frame side presents an address with a one-cycle strobe and receives, one clock later, a result pulse carrying the accept decision and the path that produced it. A saturating counter records how many frames were accepted through the hash path.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset every exact entry is invalid, every hash bit is clear, `mc_count` is zero and `res_valid` is low; any lookup then returns accept 0, kind 0.
- R2: `res_valid` pulses exactly one cycle after `lk_valid`, never otherwise. `res_kind` encodes 0 = none, 1 = exact, 2 = hash, and 3 never appears. `res_accept` is 1 exactly when the kind is not 0.
- R3: Exact entries are written with `wr_tbl`=0. `wr_addr[4:1]` selects the entry and `wr_addr[0]` selects the word (0 = low, 1 = high). Address byte i sits at bits 8*(i mod 4) of its word: bytes 0-3 go in the low word and bytes 4-5 in the high word's bits 15:0. Bit 31 of the high word is the entry's valid flag.
- R4: A valid entry whose six bytes equal the destination (byte i = `lk_addr[8i+7:8i]`) yields kind exact. An entry whose valid flag is clear never matches.
- R5: An exact match takes priority over the hash path, and an exact match does not change `mc_count`.
- R6: With no exact match, the hash is ({byte5,byte4} >> s) masked to 12 bits. The shift s is 4, 3, 2 or 0 for `hash_ofs` codes 0, 1, 2 and 3.
- R7: The hash table is 128 words of 32 bits, written with `wr_tbl`=1 at word `wr_addr[6:0]`. Hash bits 11:5 select the word and bits 4:0 select the bit. A set bit gives kind hash and a clear bit gives kind none.
- R8: Each hash-path accept increments `mc_count` in the same edge that raises the result. The count holds at all ones instead of wrapping. No other event changes it.
- R9: A table write in the same cycle as `lk_valid` does not affect that lookup; it applies from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | 0 = exact table, 1 = hash table |
| wr_addr | input | 7 | Word address within the selected table |
| wr_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte i at bits 8i+7:8i |
| hash_ofs | input | 2 | Hash window selection code |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_kind | output | 2 | Match kind: 0 none, 1 exact, 2 hash |
| mc_count | output | CNT_W | Saturating hash-accept count |

## Verification
On every cycle, the assertions check the one-cycle result timing, the legal kind codes and their agreement with the accept flag, and the counter rules: it rises by one only on a hash result, saturates, and otherwise stays still. Only the bench's scenarios can show that the right entry or hash bit decides the outcome. The same holds for the per-code shift window, the skipping of invalid entries, exact-over-hash priority and the deferred effect of a write that coincides with a lookup, because each of these depends on table contents that the checker cannot see.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W   = 48;
    localparam int HASH_W   = 12;
    localparam int WORD_W   = 32;
    localparam int BIT_W    = $clog2(WORD_W);
    localparam int HWORDS   = (1 << HASH_W) / WORD_W;
    localparam int HIDX_W   = $clog2(HWORDS);
    localparam int VALID_BIT = 31;

    typedef enum logic [1:0] {
        MK_NONE  = 2'd0,
        MK_EXACT = 2'd1,
        MK_HASH  = 2'd2
    } match_kind_e;

    typedef struct packed {
        logic [HIDX_W-1:0] word;
        logic [BIT_W-1:0]  bit_sel;
    } hash_pos_t;

    // Right shift applied to the upper address half for each window code
    function automatic logic [2:0] window_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd4;
            2'd1:    return 3'd3;
            2'd2:    return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

    function automatic hash_pos_t hash_of(input logic [15:0] upper, input logic [1:0] code);
        logic [15:0] sh;
        sh = upper >> window_shift(code);
        return hash_pos_t'(sh[HASH_W-1:0]);
    endfunction

endpackage

// File: rtl/rxf_exact_table.sv
module rxf_exact_table
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit
);

    logic [N_ENTRIES-1:0] hit_vec;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        logic [WORD_W-1:0] lo_q;
        logic [WORD_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                if (wr_hi) hi_q <= wr_data;
                else       lo_q <= wr_data;
            end
        end

        assign hit_vec[e] = hi_q[VALID_BIT]
                         && (lo_q == lk_addr[31:0])
                         && (hi_q[15:0] == lk_addr[47:32]);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HIDX_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [15:0]       lk_upper,
    input  logic [1:0]        lk_code,
    output logic              bit_set
);

    logic [WORD_W-1:0] words_q [HWORDS];
    hash_pos_t         pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < HWORDS; w++) words_q[w] <= '0;
        end else if (wr_en) begin
            words_q[wr_word] <= wr_data;
        end
    end

    always_comb begin
        pos     = hash_of(lk_upper, lk_code);
        bit_set = words_q[pos.word][pos.bit_sel];
    end

endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)                    count <= '0;
        else if (inc && ~&count)    count <= count + W'(1);
    end

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_tbl,
    input  logic [6:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              lk_valid,
    input  logic [47:0]       lk_addr,
    input  logic [1:0]        hash_ofs,
    output logic              res_valid,
    output logic              res_accept,
    output logic [1:0]        res_kind,
    output logic [CNT_W-1:0]  mc_count
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic        ex_hit;
    logic        h_set;
    match_kind_e kind_d;
    match_kind_e kind_q;

    rxf_exact_table #(.N_ENTRIES(N_ENTRIES)) u_exact (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && !wr_tbl),
        .wr_idx  (wr_addr[IDX_W:1]),
        .wr_hi   (wr_addr[0]),
        .wr_data (wr_data),
        .lk_addr (lk_addr),
        .hit     (ex_hit)
    );

    rxf_hash_table u_hash (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && wr_tbl),
        .wr_word  (wr_addr[HIDX_W-1:0]),
        .wr_data  (wr_data),
        .lk_upper (lk_addr[47:32]),
        .lk_code  (hash_ofs),
        .bit_set  (h_set)
    );

    always_comb begin
        if (!lk_valid)   kind_d = MK_NONE;
        else if (ex_hit) kind_d = MK_EXACT;
        else if (h_set)  kind_d = MK_HASH;
        else             kind_d = MK_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            kind_q    <= MK_NONE;
        end else begin
            res_valid <= lk_valid;
            kind_q    <= kind_d;
        end
    end

    assign res_kind   = kind_q;
    assign res_accept = (kind_q != MK_NONE);

    rxf_sat_counter #(.W(CNT_W)) u_mc (
        .clk   (clk),
        .rst   (rst),
        .inc   (kind_d == MK_HASH),
        .count (mc_count)
    );

endmodule

// File: rtl/rxf_addr_filter_chk.sv
module rxf_addr_filter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_accept,
    input logic [1:0]       res_kind,
    input logic [CNT_W-1:0] mc_count
);

    assert_result_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(lk_valid));

    assert_kind_legal_R2: assert property (@(posedge clk) disable iff (rst)
        res_kind != 2'd3);

    assert_accept_matches_kind_R2: assert property (@(posedge clk) disable iff (rst)
        res_accept == (res_valid && res_kind != 2'd0));

    assert_count_steps_on_hash_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd2 && ~&$past(mc_count)) |-> mc_count == $past(mc_count) + CNT_W'(1));

    assert_count_saturates_R8: assert property (@(posedge clk) disable iff (rst)
        (&$past(mc_count)) |-> &mc_count);

    assert_count_still_otherwise_R8: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_kind == 2'd2) |-> $stable(mc_count));

endmodule

bind rxf_addr_filter rxf_addr_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_kind   (res_kind),
    .mc_count   (mc_count)
);

// File: tb/test_rxf_addr_filter.sv
module test_rxf_addr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_tbl = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          lk_valid = 1'b0;
    logic [47:0]   lk_addr = '0;
    logic [1:0]    hash_ofs = '0;
    logic          res_valid;
    logic          res_accept;
    logic [1:0]    res_kind;
    logic [CW-1:0] mc_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_addr_filter #(.N_ENTRIES(16), .CNT_W(CW)) i_rxf_addr_filter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_addr(wr_addr),
        .wr_data(wr_data), .lk_valid(lk_valid), .lk_addr(lk_addr), .hash_ofs(hash_ofs),
        .res_valid(res_valid), .res_accept(res_accept), .res_kind(res_kind), .mc_count(mc_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hash position computed from the requirement text
    function automatic int unsigned hash_bitpos(input logic [47:0] a, input logic [1:0] code);
        int unsigned up, sh;
        up = {a[47:40], a[39:32]};
        sh = (code == 0) ? 4 : (code == 1) ? 3 : (code == 2) ? 2 : 0;
        return (up >> sh) & 12'hFFF;
    endfunction

    task automatic write_word(input logic tbl, input logic [6:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = tbl; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_entry(input int idx, input logic [47:0] a, input logic v);
        write_word(1'b0, 7'((idx << 1) | 0), a[31:0]);
        write_word(1'b0, 7'((idx << 1) | 1), {v, 15'd0, a[47:32]});
    endtask

    task automatic lookup(input logic [47:0] a, input logic [1:0] code);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; hash_ofs = code;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic acc, input logic [1:0] kind);
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " accept"}, 32'(res_accept), 32'(acc));
        check({req, " kind"}, 32'(res_kind), 32'(kind));
    endtask

    task automatic t_reset;
        check("R1 idle valid", 32'(res_valid), 0);
        check("R1 count", 32'(mc_count), 0);
        for (int c = 0; c < 4; c++) begin
            lookup(48'h0000_0000_0000, 2'(c));
            expect_res("R1 empty tables", 1'b0, 2'd0);
        end
        @(negedge clk);
        check("R2 single pulse", 32'(res_valid), 0);
    endtask

    task automatic t_exact;
        logic [47:0] a = 48'h6655_4433_2211;
        write_entry(3, a, 1'b1);
        lookup(a, 2'd0);
        expect_res("R4 exact hit", 1'b1, 2'd1);
        lookup(a ^ 48'h0100_0000_0000, 2'd0);
        expect_res("R3 byte5 differs", 1'b0, 2'd0);
        lookup(a ^ 48'h0000_0000_0080, 2'd0);
        expect_res("R3 byte0 differs", 1'b0, 2'd0);
        write_entry(15, 48'hAABB_CCDD_EEFF, 1'b0);
        lookup(48'hAABB_CCDD_EEFF, 2'd3);
        expect_res("R4 invalid entry skipped", 1'b0, 2'd0);
        check("R5 exact leaves count", 32'(mc_count), 0);
    endtask

    task automatic t_hash_windows;
        logic [47:0] a = 48'h1234_0000_0001;
        int unsigned p = hash_bitpos(a, 2'd2);
        write_word(1'b1, 7'(p >> 5), 32'd1 << (p & 31));
        for (int c = 0; c < 4; c++) begin
            lookup(a, 2'(c));
            if (c == 2) expect_res("R6 R7 selected window", 1'b1, 2'd2);
            else        expect_res("R6 other window miss", 1'b0, 2'd0);
        end
        check("R8 count after one hash", 32'(mc_count), 1);
    endtask

    task automatic t_priority;
        logic [47:0] a = 48'h1234_0000_0001;
        write_entry(7, a, 1'b1);
        lookup(a, 2'd2);
        expect_res("R5 exact over hash", 1'b1, 2'd1);
        check("R5 count unchanged", 32'(mc_count), 1);
        write_entry(7, a, 1'b0);
    endtask

    task automatic t_same_cycle;
        logic [47:0] a = 48'h0A0B_0C0D_0E0F;
        write_entry(5, a, 1'b1);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; hash_ofs = 2'd0;
        wr_en = 1'b1; wr_tbl = 1'b0; wr_addr = 7'd11; wr_data = {1'b0, 15'd0, a[47:32]};
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b0;
        expect_res("R9 old contents used", 1'b1, 2'd1);
        lookup(a, 2'd0);
        expect_res("R9 write then visible", 1'b0, 2'd0);
    endtask

    task automatic t_saturate;
        logic [47:0] a = 48'h1234_0000_0001;
        for (int k = 0; k < 8; k++) begin
            lookup(a, 2'd2);
            expect_res("R8 hash accept", 1'b1, 2'd2);
        end
        check("R8 saturated", 32'(mc_count), 7);
        write_word(1'b1, 7'(hash_bitpos(a, 2'd2) >> 5), 32'd0);
        lookup(a, 2'd2);
        expect_res("R7 cleared bit rejects", 1'b0, 2'd0);
        check("R8 held at max", 32'(mc_count), 7);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exact();
        t_hash_windows();
        t_priority();
        t_same_cycle();
        t_saturate();
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule